// File: doc/BRIEF.md
# Low-Power Mode Controller

This block chooses the power state of a small microcontroller and drives the enables, resets and hold controls that put the CPU, the peripherals, the I/O pins and the RAM into that state. It is clocked by the system clock. One clock period is one state, and every decision takes effect at a rising edge.

Software picks between two kinds of low-power state with a standby-select bit in a small configuration register. When the CPU executes its sleep instruction, a clear bit gives a light sleep in which the peripherals keep running. A set bit gives a deep software standby: the peripherals are stopped and held in reset, and the pins keep their last values.

An active-low hardware standby pin overrides everything else. It stops all functions, floats the I/O and keeps the RAM. When the pin is released, the CPU stays in reset until a programmable oscillator-settling count has run out. The same count delays the return to run after a wake from software standby.

Top module: `lpm_ctrl`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it, mode_o is 00 (run). In that state cpu_clk_en_o and per_clk_en_o are 1 and per_rst_o, cpu_rst_o, io_hold_o, io_hiz_o and ram_ret_o are 0. The configuration register resets to standby-select 0 and settle count 0.
- R2: In run, a sleep_i pulse while the stored standby-select bit is 0 enters sleep at the next edge. Sleep sets mode_o 01, cpu_clk_en_o 0, per_clk_en_o 1 and ram_ret_o 1, with no peripheral reset.
- R3: In run, a sleep_i pulse while the stored standby-select bit is 1 enters software standby at the next edge. Software standby sets mode_o 10, both clock enables 0, per_rst_o 1, io_hold_o 1, io_hiz_o 0 and ram_ret_o 1.
- R4: In sleep, wake_i returns the controller to run at the next edge.
- R5: In software standby, wake_i starts a settling phase that copies the stored settle count N. The controller stays at mode_o 10 for N+1 more cycles with the standby outputs unchanged, then enters run.
- R6: hw_stby_ni low at an edge enters hardware standby from any state. Hardware standby sets mode_o 11, both clock enables 0, per_rst_o 1, cpu_rst_o 1, io_hiz_o 1, io_hold_o 0 and ram_ret_o 1.
- R7: While hw_stby_ni is low, sleep_i and wake_i have no effect, and the controller stays in hardware standby.
- R8: When hw_stby_ni returns high, the controller keeps mode_o 11, cpu_rst_o 1 and all other hardware-standby outputs for N+1 cycles, where N is the stored settle count, and then enters run. hw_stby_ni going low again during that time restarts hardware standby.
- R9: mode_o encodes the state as 00 run, 01 sleep, 10 software standby (including its settling phase) and 11 hardware standby (including its recovery).
- R10: The standby-select bit and the settle count are loaded from cfg_ssby_i and cfg_settle_i only at an edge where cfg_we_i is 1. Values presented with cfg_we_i at 0 change nothing.
- R11: wake_i has no effect in run or during settling. sleep_i has no effect outside run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hw_stby_ni | input | 1 | Hardware standby request, active low |
| sleep_i | input | 1 | Sleep instruction strobe from the CPU |
| wake_i | input | 1 | Wake interrupt or external wake |
| cfg_we_i | input | 1 | Configuration register write enable |
| cfg_ssby_i | input | 1 | Standby-select bit to write |
| cfg_settle_i | input | CNT_W | Settling count to write |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| per_rst_o | output | 1 | Peripheral reset |
| cpu_rst_o | output | 1 | CPU reset during hardware standby and recovery |
| io_hold_o | output | 1 | Hold I/O outputs at their last values |
| io_hiz_o | output | 1 | Float all I/O outputs |
| ram_ret_o | output | 1 | RAM retention flag |
| mode_o | output | 2 | Current mode encoding |

## Verification
On every cycle, the assertions check three things. The hardware standby pin always wins at the next edge. Sleep and wake follow the standby-select bit held in the configuration register. The settling and recovery phases hold until the counter reports done. The exact length of the settling windows, a zero count, the ignored strobes and a re-assertion of the pin during recovery depend on input histories. Only the bench scenarios show these, because the bench's behavioural model is compared with every output on every clock.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [2:0] {
    ST_RUN, ST_SLEEP, ST_SSTBY, ST_SETTLE, ST_HSTBY, ST_HREC
  } lpm_state_e;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'b00,
    MODE_SLEEP = 2'b01,
    MODE_SSTBY = 2'b10,
    MODE_HSTBY = 2'b11
  } lpm_mode_e;
endpackage

// File: rtl/lpm_cfg.sv
module lpm_cfg #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             ssby_i,
  input  logic [CNT_W-1:0] settle_i,
  output logic             ssby_o,
  output logic [CNT_W-1:0] settle_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ssby_o   <= 1'b0;
      settle_o <= '0;
    end else if (we_i) begin
      ssby_o   <= ssby_i;
      settle_o <= settle_i;
    end
  end
endmodule

// File: rtl/lpm_settle.sv
module lpm_settle #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] settle_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= settle_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hw_stby_ni,
  input  logic       sleep_i,
  input  logic       wake_i,
  input  logic       ssby_i,
  input  logic       done_i,
  output lpm_state_e state_o,
  output logic       load_o
);
  lpm_state_e nxt;

  always_comb begin
    nxt = state_o;
    if (!hw_stby_ni) nxt = ST_HSTBY;  // pin overrides all
    else begin
      unique case (state_o)
        ST_RUN:    if (sleep_i) nxt = ssby_i ? ST_SSTBY : ST_SLEEP;
        ST_SLEEP:  if (wake_i)  nxt = ST_RUN;
        ST_SSTBY:  if (wake_i)  nxt = ST_SETTLE;
        ST_SETTLE: if (done_i)  nxt = ST_RUN;
        ST_HSTBY:               nxt = ST_HREC;
        ST_HREC:   if (done_i)  nxt = ST_RUN;
        default:                nxt = ST_RUN;
      endcase
    end
  end

  assign load_o = (nxt == ST_SETTLE && state_o != ST_SETTLE) ||
                  (nxt == ST_HREC   && state_o != ST_HREC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_o <= ST_RUN;
    else         state_o <= nxt;
  end

  assert_hstby_entry_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hw_stby_ni |=> state_o == ST_HSTBY);
  assert_sleep_select_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_RUN && hw_stby_ni && sleep_i && !ssby_i) |=> state_o == ST_SLEEP);
  assert_sstby_select_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_RUN && hw_stby_ni && sleep_i && ssby_i) |=> state_o == ST_SSTBY);
  assert_sleep_wake_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_SLEEP && hw_stby_ni && wake_i) |=> state_o == ST_RUN);
  assert_settle_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_SETTLE && hw_stby_ni && !done_i) |=> state_o == ST_SETTLE);
  assert_recover_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_HREC && hw_stby_ni && !done_i) |=> state_o == ST_HREC);
endmodule

// File: rtl/lpm_decode.sv
module lpm_decode
  import lpm_pkg::*;
(
  input  lpm_state_e state_i,
  output logic       cpu_clk_en_o,
  output logic       per_clk_en_o,
  output logic       per_rst_o,
  output logic       cpu_rst_o,
  output logic       io_hold_o,
  output logic       io_hiz_o,
  output logic       ram_ret_o,
  output logic [1:0] mode_o
);
  always_comb begin
    cpu_clk_en_o = 1'b0;
    per_clk_en_o = 1'b0;
    per_rst_o    = 1'b1;
    cpu_rst_o    = 1'b0;
    io_hold_o    = 1'b0;
    io_hiz_o     = 1'b0;
    ram_ret_o    = 1'b1;
    mode_o       = MODE_RUN;
    unique case (state_i)
      ST_RUN: begin
        cpu_clk_en_o = 1'b1;
        per_clk_en_o = 1'b1;
        per_rst_o    = 1'b0;
        ram_ret_o    = 1'b0;
      end
      ST_SLEEP: begin
        per_clk_en_o = 1'b1;
        per_rst_o    = 1'b0;
        mode_o       = MODE_SLEEP;
      end
      ST_SSTBY, ST_SETTLE: begin
        io_hold_o = 1'b1;
        mode_o    = MODE_SSTBY;
      end
      ST_HSTBY, ST_HREC: begin
        cpu_rst_o = 1'b1;
        io_hiz_o  = 1'b1;
        mode_o    = MODE_HSTBY;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hw_stby_ni,
  input  logic             sleep_i,
  input  logic             wake_i,
  input  logic             cfg_we_i,
  input  logic             cfg_ssby_i,
  input  logic [CNT_W-1:0] cfg_settle_i,
  output logic             cpu_clk_en_o,
  output logic             per_clk_en_o,
  output logic             per_rst_o,
  output logic             cpu_rst_o,
  output logic             io_hold_o,
  output logic             io_hiz_o,
  output logic             ram_ret_o,
  output logic [1:0]       mode_o
);
  logic             ssby_q;
  logic [CNT_W-1:0] settle_q;
  logic             load, done;
  lpm_state_e       state;

  lpm_cfg #(.CNT_W(CNT_W)) u_cfg (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .ssby_i(cfg_ssby_i),
    .settle_i(cfg_settle_i), .ssby_o(ssby_q), .settle_o(settle_q)
  );

  lpm_settle #(.CNT_W(CNT_W)) u_settle (
    .clk_i, .rst_ni, .load_i(load), .settle_i(settle_q), .done_o(done)
  );

  lpm_fsm u_fsm (
    .clk_i, .rst_ni, .hw_stby_ni, .sleep_i, .wake_i,
    .ssby_i(ssby_q), .done_i(done), .state_o(state), .load_o(load)
  );

  lpm_decode u_dec (
    .state_i(state), .cpu_clk_en_o, .per_clk_en_o, .per_rst_o, .cpu_rst_o,
    .io_hold_o, .io_hiz_o, .ram_ret_o, .mode_o
  );

  assert_hiz_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_hiz_o |-> (!io_hold_o && !cpu_clk_en_o && !per_clk_en_o));
  assert_pin_ignore_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hw_stby_ni && mode_o == MODE_HSTBY) |=> (mode_o == MODE_HSTBY && cpu_rst_o));
endmodule

// File: tb/lpm_ctrl_bench.sv
module lpm_ctrl_bench;
  localparam int CNT_W = 8;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic hw_stby_ni = 1'b1, sleep_i = 1'b0, wake_i = 1'b0;
  logic cfg_we_i = 1'b0, cfg_ssby_i = 1'b0;
  logic [CNT_W-1:0] cfg_settle_i = '0;
  logic cpu_clk_en_o, per_clk_en_o, per_rst_o, cpu_rst_o, io_hold_o, io_hiz_o, ram_ret_o;
  logic [1:0] mode_o;

  int compared = 0, mismatched = 0;
  bit finished = 0;
  string tag = "R1";

  always #2.5 clk_i = ~clk_i;

  lpm_ctrl #(.CNT_W(CNT_W)) u_lpm_ctrl (.*);

  // Behavioural model: 0 run,1 sleep,2 sw standby,3 settling,4 hw standby,5 recovery
  int m_st = 0, m_cnt = 0, m_settle = 0;
  bit m_ssby = 0;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_cnt = 0; m_settle = 0; m_ssby = 0;
    end else begin
      if (!hw_stby_ni) m_st = 4;
      else case (m_st)
        0: if (sleep_i) m_st = m_ssby ? 2 : 1;
        1: if (wake_i) m_st = 0;
        2: if (wake_i) begin m_st = 3; m_cnt = m_settle; end
        3: if (m_cnt == 0) m_st = 0; else m_cnt--;
        4: begin m_st = 5; m_cnt = m_settle; end
        5: if (m_cnt == 0) m_st = 0; else m_cnt--;
        default: m_st = 0;
      endcase
      if (cfg_we_i) begin m_ssby = cfg_ssby_i; m_settle = int'(cfg_settle_i); end
    end
  end

  task automatic cmp(string what, string req, logic [1:0] act, logic [1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s [%s] %s at %0t: actual %0d expected %0d", req, tag, what, $time, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    logic [1:0] e_mode;
    if (!finished) begin
      e_mode = (m_st == 0) ? 2'd0 : (m_st == 1) ? 2'd1 : (m_st <= 3) ? 2'd2 : 2'd3;
      cmp("mode_o",       "R9", mode_o,       e_mode);
      cmp("cpu_clk_en_o", "R2", {1'b0, cpu_clk_en_o}, {1'b0, m_st == 0});
      cmp("per_clk_en_o", "R3", {1'b0, per_clk_en_o}, {1'b0, m_st <= 1});
      cmp("per_rst_o",    "R3", {1'b0, per_rst_o},    {1'b0, m_st >= 2});
      cmp("io_hold_o",    "R3", {1'b0, io_hold_o},    {1'b0, m_st == 2 || m_st == 3});
      cmp("io_hiz_o",     "R6", {1'b0, io_hiz_o},     {1'b0, m_st >= 4});
      cmp("cpu_rst_o",    "R8", {1'b0, cpu_rst_o},    {1'b0, m_st >= 4});
      cmp("ram_ret_o",    "R2", {1'b0, ram_ret_o},    {1'b0, m_st != 0});
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr_cfg(bit ssby, int settle);
    cfg_we_i = 1; cfg_ssby_i = ssby; cfg_settle_i = CNT_W'(settle);
    tick(1);
    cfg_we_i = 0;
  endtask

  task automatic pulse_sleep();
    sleep_i = 1; tick(1); sleep_i = 0;
  endtask

  task automatic pulse_wake();
    wake_i = 1; tick(1); wake_i = 0;
  endtask

  initial begin
    tag = "R1"; tick(3); rst_ni = 1; tick(2);
    tag = "R2"; pulse_sleep(); tick(3);
    tag = "R11"; pulse_sleep(); tick(1);          // sleep ignored in sleep
    tag = "R4"; pulse_wake(); tick(2);
    tag = "R11"; pulse_wake(); tick(2);           // wake ignored in run
    tag = "R10"; wr_cfg(1, 3);
    cfg_ssby_i = 0; cfg_settle_i = 8'd7; tick(2); // no write enable
    tag = "R3"; pulse_sleep(); tick(3);
    tag = "R11"; pulse_sleep(); tick(1);
    tag = "R5"; pulse_wake(); pulse_wake(); tick(6); // second wake during settling
    tag = "R5"; wr_cfg(1, 0); pulse_sleep(); tick(2); pulse_wake(); tick(3);
    tag = "R6"; hw_stby_ni = 0; tick(3);
    tag = "R7"; sleep_i = 1; wake_i = 1; tick(3); sleep_i = 0; wake_i = 0;
    tag = "R8"; hw_stby_ni = 1; tick(3);
    tag = "R8"; wr_cfg(0, 5); hw_stby_ni = 0; tick(2); hw_stby_ni = 1; tick(3);
    hw_stby_ni = 0; tick(1); hw_stby_ni = 1; tick(10);
    tag = "R6"; pulse_sleep(); tick(2); hw_stby_ni = 0; tick(2); hw_stby_ni = 1; tick(8);
    tag = "R6"; wr_cfg(1, 4); pulse_sleep(); tick(2); pulse_wake(); tick(1);
    hw_stby_ni = 0; tick(2); hw_stby_ni = 1; tick(8);
    tag = "R2"; wr_cfg(0, 2); pulse_sleep(); tick(2); pulse_wake(); tick(3);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #20000;
    if (!finished) begin
      finished = 1;
      mismatched++;
      $display("FAIL watchdog [%s]: actual timeout expected completion", tag);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule